// File: doc/BRIEF.md
# Stack-Machine Datapath Register Bank

This block holds the working registers of a microcoded stack-machine datapath and connects them to the two internal buses. A 4-bit source code picks the one register that drives the B bus into the ALU, and a 9-bit write mask loads the C bus result into any subset of registers on the clock edge. The holding register feeds the ALU's A input directly, with no selector.

Bus access is uneven. The memory-address register can be loaded from the C bus but never drives the B bus. The opcode byte register is loaded only by the instruction-fetch port and has no C-bus write path. When it drives the B bus it is widened to 32 bits, either sign-extended or zero-extended. The memory-data register has two write sources: the C bus and the memory read port.

The memory address, memory write data and fetch address leave the block directly from their registers. The ALU, the shifter, the memory controller and the microcode sequencer are outside this block.

Top module: `ucode_regfile`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every register becomes zero, including the opcode byte.
- R2: Each set bit of `c_wr_mask` loads `c_bus` into one register at the rising edge. The bit positions are: 0 stack pointer, 1 frame pointer, 2 constant-pool pointer, 3 top-of-stack value, 4 scratch, 5 ALU hold, 6 memory address, 7 memory data, 8 program counter.
- R3: A register whose mask bit is clear keeps its value, and several mask bits set together all load the same `c_bus` value.
- R4: `b_bus` follows `b_sel` combinationally, with no clock edge in between. Codes 0 to 6 select, in order: stack pointer, frame pointer, constant-pool pointer, top-of-stack, scratch, memory data, program counter.
- R5: `b_sel` code 7 drives the opcode byte sign-extended to 32 bits.
- R6: `b_sel` code 8 drives the opcode byte zero-extended to 32 bits.
- R7: `b_sel` codes 9 to 15 drive zero.
- R8: No `b_sel` code places the memory-address register on `b_bus`.
- R9: The opcode byte loads `fetch_byte` only when `fetch_valid` is high. A C-bus write with any mask leaves it unchanged.
- R10: When `mem_rd_valid` is high, the memory-data register loads `mem_rd_data` at the rising edge.
- R11: When the memory load and C-bus mask bit 7 target the memory-data register in the same cycle, the memory value is stored. The other mask bits still take effect in that cycle.
- R12: `alu_a`, `mem_addr`, `mem_wdata` and `fetch_addr` show the ALU hold, memory-address, memory-data and program-counter registers respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| c_bus | input | 32 | Result bus to be written into registers |
| c_wr_mask | input | 9 | One bit per C-bus writable register |
| b_sel | input | 4 | B-bus source code |
| b_bus | output | 32 | Selected register value toward the ALU |
| alu_a | output | 32 | ALU hold register, fixed A operand |
| mem_rd_valid | input | 1 | Load memory-data register from memory |
| mem_rd_data | input | 32 | Data returned by a memory read |
| fetch_valid | input | 1 | Load opcode byte from instruction fetch |
| fetch_byte | input | 8 | Fetched opcode byte |
| mem_addr | output | 32 | Data memory address |
| mem_wdata | output | 32 | Data memory write value |
| fetch_addr | output | 32 | Instruction fetch address |

## Verification
The bench loads an opcode byte with its top bit set and one with it clear. A design that mixed up the two extension codes, or extended with the wrong bit, would put the wrong upper 24 bits on the B bus. It writes a distinctive value only into the memory-address register and scans all sixteen source codes; a mux that leaked that register onto the bus, or drove something other than zero on unused codes, would show it. It also drives the memory load and a C-bus write to the memory-data register in the same cycle, which a design with the priority reversed would resolve to the C-bus value. A full-mask write is applied while the opcode byte holds a known value, to catch a stray C-bus write path into that byte.

// File: rtl/ucode_regfile_pkg.sv
// Package: shared constants for the datapath register bank.
// Assumes a 32-bit datapath, an 8-bit opcode and a 4-bit B source code.
package ucode_regfile_pkg;

    localparam int DATA_W   = 32;
    localparam int OP_W     = 8;
    localparam int SEL_W    = 4;
    localparam int NUM_CREG = 9;

    // Write-mask bit positions, one for each C-bus writable register
    localparam int W_STK   = 0;
    localparam int W_FRAME = 1;
    localparam int W_POOL  = 2;
    localparam int W_TOP   = 3;
    localparam int W_SCR   = 4;
    localparam int W_HOLD  = 5;
    localparam int W_MADDR = 6;
    localparam int W_MDATA = 7;
    localparam int W_PCNT  = 8;

    // B-bus source codes; every code not listed drives zero
    typedef enum logic [3:0] {
        BS_STK   = 4'd0,
        BS_FRAME = 4'd1,
        BS_POOL  = 4'd2,
        BS_TOP   = 4'd3,
        BS_SCR   = 4'd4,
        BS_MDATA = 4'd5,
        BS_PCNT  = 4'd6,
        BS_OP_SX = 4'd7,
        BS_OP_ZX = 4'd8
    } bsel_e;

endpackage

// File: rtl/regfile_word.sv
// Module: regfile_word
// A single datapath register with one write source and synchronous
// active-low reset. Assumes the write enable is already decoded.
module regfile_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, otherwise load when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !we) |=> $stable(q));

    // R2
    load_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && we) |=> (q == $past(d)));

endmodule

// File: rtl/regfile_mdata.sv
// Module: regfile_mdata
// The memory-data register. It has two write sources, the C bus and
// memory read data. Assumes the memory load takes priority when both
// are requested in the same cycle.
module regfile_mdata #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         c_we,
    input  logic [W-1:0] c_d,
    input  logic         m_we,
    input  logic [W-1:0] m_d,
    output logic [W-1:0] q
);

    // Reset, then memory load, then C-bus load, in that priority
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (m_we) q <= m_d;
        else if (c_we) q <= c_d;
    end

    // R10 R11
    mem_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && m_we) |=> (q == $past(m_d)));

    // R2
    cbus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && c_we && !m_we) |=> (q == $past(c_d)));

    // R3
    mdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !c_we && !m_we) |=> $stable(q));

endmodule

// File: rtl/regfile_bsel.sv
// Module: regfile_bsel
// B-bus source multiplexer. Selects one of seven word registers, or the
// opcode byte widened by sign or zero extension. Unused codes drive zero.
// The memory-address register is deliberately not an input.
module regfile_bsel
    import ucode_regfile_pkg::*;
#(
    parameter int DW = 32,
    parameter int OW = 8,
    parameter int SW = 4
) (
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] stk,
    input  logic [DW-1:0] frame,
    input  logic [DW-1:0] pool,
    input  logic [DW-1:0] top,
    input  logic [DW-1:0] scr,
    input  logic [DW-1:0] mdata,
    input  logic [DW-1:0] pcnt,
    input  logic [OW-1:0] op,
    output logic [DW-1:0] bus
);

    localparam int EXT_W = DW - OW;

    logic [DW-1:0] op_sx;
    logic [DW-1:0] op_zx;

    // Widen the opcode byte both ways
    always_comb begin
        op_sx = {{EXT_W{op[OW-1]}}, op};
        op_zx = {{EXT_W{1'b0}}, op};
    end

    // Route the selected source onto the bus
    always_comb begin
        case (sel)
            SW'(BS_STK):   bus = stk;
            SW'(BS_FRAME): bus = frame;
            SW'(BS_POOL):  bus = pool;
            SW'(BS_TOP):   bus = top;
            SW'(BS_SCR):   bus = scr;
            SW'(BS_MDATA): bus = mdata;
            SW'(BS_PCNT):  bus = pcnt;
            SW'(BS_OP_SX): bus = op_sx;
            SW'(BS_OP_ZX): bus = op_zx;
            default:       bus = '0;
        endcase
    end

endmodule

// File: rtl/ucode_regfile.sv
// Module: ucode_regfile (top)
// Register bank of the stack-machine datapath. Nine word registers are
// written from the C bus under a one-hot-per-register mask; the
// memory-data register can also be loaded from memory; the opcode byte is
// loaded only from the fetch port. Assumes the mask bit positions fixed in
// ucode_regfile_pkg and a synchronous active-low reset.
module ucode_regfile
    import ucode_regfile_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OP_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] c_bus,
    input  logic [NUM_CREG-1:0] c_wr_mask,
    input  logic [SW-1:0] b_sel,
    output logic [DW-1:0] b_bus,
    output logic [DW-1:0] alu_a,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    input  logic          fetch_valid,
    input  logic [OW-1:0] fetch_byte,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] fetch_addr
);

    localparam int NR = NUM_CREG;

    logic [NR-1:0][DW-1:0] rq;
    logic [OW-1:0]         op_q;

    // One register per mask bit; the memory-data slot takes two sources
    for (genvar i = 0; i < NR; i++) begin : g_reg
        if (i == W_MDATA) begin : g_mdata
            regfile_mdata #(.W(DW)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .c_we (c_wr_mask[i]),
                .c_d  (c_bus),
                .m_we (mem_rd_valid),
                .m_d  (mem_rd_data),
                .q    (rq[i])
            );
        end else begin : g_word
            regfile_word #(.W(DW)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .we   (c_wr_mask[i]),
                .d    (c_bus),
                .q    (rq[i])
            );
        end
    end

    // Opcode byte: loaded from the fetch port only
    always_ff @(posedge clk) begin
        if (!rst_n)           op_q <= '0;
        else if (fetch_valid) op_q <= fetch_byte;
    end

    regfile_bsel #(.DW(DW), .OW(OW), .SW(SW)) u_bsel (
        .sel  (b_sel),
        .stk  (rq[W_STK]),
        .frame(rq[W_FRAME]),
        .pool (rq[W_POOL]),
        .top  (rq[W_TOP]),
        .scr  (rq[W_SCR]),
        .mdata(rq[W_MDATA]),
        .pcnt (rq[W_PCNT]),
        .op   (op_q),
        .bus  (b_bus)
    );

    // Drive the fixed outputs straight from their registers
    always_comb begin
        alu_a      = rq[W_HOLD];
        mem_addr   = rq[W_MADDR];
        mem_wdata  = rq[W_MDATA];
        fetch_addr = rq[W_PCNT];
    end

    // R9
    op_byte_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !fetch_valid) |=> $stable(op_q));

    // R5
    sx_upper_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel == SW'(BS_OP_SX)) |-> (b_bus[DW-1:OW] == {(DW-OW){b_bus[OW-1]}}));

    // R6
    zx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel == SW'(BS_OP_ZX)) |-> (b_bus[DW-1:OW] == '0));

    // R7
    unused_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel > SW'(BS_OP_ZX)) |-> (b_bus == '0));

    // R12
    maddr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && c_wr_mask[W_MADDR]) |=> (mem_addr == $past(c_bus)));

endmodule

// File: tb/ucode_regfile_test.sv
// Directed bench for ucode_regfile. It keeps its own model of the
// registers, derived from the requirements, and compares every observable
// output after each step.
module ucode_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] c_bus;
    logic [8:0]  c_wr_mask;
    logic [3:0]  b_sel;
    logic [31:0] b_bus;
    logic [31:0] alu_a;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        fetch_valid;
    logic [7:0]  fetch_byte;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] fetch_addr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [9];
    logic [7:0]  model_op;

    ucode_regfile uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .c_bus       (c_bus),
        .c_wr_mask   (c_wr_mask),
        .b_sel       (b_sel),
        .b_bus       (b_bus),
        .alu_a       (alu_a),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .fetch_valid (fetch_valid),
        .fetch_byte  (fetch_byte),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .fetch_addr  (fetch_addr)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // One clock edge, then idle the strobes; inputs change 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
        c_wr_mask    = '0;
        mem_rd_valid = 1'b0;
        fetch_valid  = 1'b0;
    endtask

    function automatic logic [31:0] bus_model(input int code);
        case (code)
            0: return model[0];
            1: return model[1];
            2: return model[2];
            3: return model[3];
            4: return model[4];
            5: return model[7];
            6: return model[8];
            7: return {{24{model_op[7]}}, model_op};
            8: return {24'h0, model_op};
            default: return 32'h0;
        endcase
    endfunction

    // Compare every B code and every fixed output against the model
    task automatic check_all(input string req);
        for (int k = 0; k < 16; k++) begin
            b_sel = 4'(k);
            #1;
            check(req, b_bus, bus_model(k));   // R4 combinational select
        end
        check({req, "/R12 alu_a"},      alu_a,      model[5]);
        check({req, "/R12 mem_addr"},   mem_addr,   model[6]);
        check({req, "/R12 mem_wdata"},  mem_wdata,  model[7]);
        check({req, "/R12 fetch_addr"}, fetch_addr, model[8]);
    endtask

    task automatic cwrite(input logic [8:0] mask, input logic [31:0] val);
        c_bus = val;
        c_wr_mask = mask;
        for (int i = 0; i < 9; i++) if (mask[i]) model[i] = val;
        step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) model[i] = '0;
        model_op = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1 reset");
    endtask

    task automatic t_single_writes();
        // R2 R3: one bit at a time, the others must hold
        for (int i = 0; i < 9; i++) begin
            cwrite(9'(1 << i), 32'h1100_0000 + 32'(i) * 32'h0101_0101);
            check_all("R2 R3 single write");
        end
    endtask

    task automatic t_multi_write();
        cwrite(9'h1FF, 32'hCAFE_F00D);
        check_all("R3 full mask");
        cwrite(9'b1_0101_0010, 32'h0BAD_0001);
        check_all("R3 partial mask");
    endtask

    task automatic t_op_byte();
        fetch_byte = 8'h85; fetch_valid = 1'b1; model_op = 8'h85;
        step();
        b_sel = 4'd7; #1; check("R5 sign extend neg", b_bus, 32'hFFFF_FF85);
        b_sel = 4'd8; #1; check("R6 zero extend neg", b_bus, 32'h0000_0085);
        fetch_byte = 8'h7F; fetch_valid = 1'b1; model_op = 8'h7F;
        step();
        b_sel = 4'd7; #1; check("R5 sign extend pos", b_bus, 32'h0000_007F);
        check_all("R5 R6 after fetch");
    endtask

    task automatic t_op_protected();
        fetch_byte = 8'hE3;   // fetch_valid stays low: must be ignored
        cwrite(9'h1FF, 32'hDEAD_BEEF);
        b_sel = 4'd8; #1; check("R9 op byte untouched", b_bus, 32'h0000_007F);
        check_all("R9 full model");
    endtask

    task automatic t_maddr_hidden();
        cwrite(9'h1FF, 32'h0000_0001);
        cwrite(9'(1 << 6), 32'hA5A5_5A5A);
        for (int k = 0; k < 16; k++) begin
            b_sel = 4'(k); #1;
            n_tests++;
            if (b_bus === 32'hA5A5_5A5A) begin
                n_fail++;
                $display("FAIL R8 code %0d: got %08h expected not %08h", k, b_bus, 32'hA5A5_5A5A);
            end
        end
        check("R12 mem_addr", mem_addr, 32'hA5A5_5A5A);
    endtask

    task automatic t_unused_codes();
        fetch_byte = 8'hFF; fetch_valid = 1'b1; model_op = 8'hFF;
        step();
        for (int k = 9; k < 16; k++) begin
            b_sel = 4'(k); #1;
            check("R7 unused code", b_bus, 32'h0);
        end
    endtask

    task automatic t_mem_load();
        mem_rd_data = 32'h1234_5678; mem_rd_valid = 1'b1; model[7] = 32'h1234_5678;
        step();
        check_all("R10 memory load");
    endtask

    task automatic t_conflict();
        c_bus = 32'hCCCC_CCCC; c_wr_mask = 9'b0_1000_0001;
        mem_rd_data = 32'h5555_AAAA; mem_rd_valid = 1'b1;
        model[0] = 32'hCCCC_CCCC; model[7] = 32'h5555_AAAA;
        step();
        b_sel = 4'd5; #1; check("R11 memory wins", b_bus, 32'h5555_AAAA);
        check_all("R11 other bits applied");
    endtask

    task automatic t_reset_again();
        cwrite(9'h1FF, 32'h7777_7777);
        do_reset();
        check_all("R1 reset after use");
    endtask

    initial begin
        rst_n = 1'b0; c_bus = '0; c_wr_mask = '0; b_sel = '0;
        mem_rd_valid = 1'b0; mem_rd_data = '0; fetch_valid = 1'b0; fetch_byte = '0;
        #1;
        t_reset();
        t_single_writes();
        t_multi_write();
        t_op_byte();
        t_op_protected();
        t_maddr_hidden();
        t_unused_codes();
        t_mem_load();
        t_conflict();
        t_reset_again();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule